// File: doc/BRIEF.md
# Store Cycle Timing Sequencer

This block produces the timed control strobes for one access cycle of a frame-store DRAM. A single-cycle start request, taken while the block is idle, launches a cycle of sixteen steps. Each step lasts a fixed number of clocks (five by default, which gives 25 ns steps at 200 MHz). The row strobe, the column strobe, the row/column address multiplexer select, a mid-cycle data window (T6), a latch-and-acknowledge pulse and a write-clear pulse each switch at fixed step numbers.

With the start request the block also latches a write-pending flag and a write-active flag. From these flags and the strobes it derives an active-low output-store enable and a row-busy flag. The write-clear pulse clears both write flags. The busy output stays high through the whole cycle. Start requests that arrive while the block is busy are ignored.

Top module: `store_cycle_seq`

## Requirements
- R1: After reset, busy, mux_sel, t6, ack and wclr are 0, ras_n and cas_n are 1, wr_pend and wr_act are 0, ostr_n is 1 and row_busy is 1.
- R2: A start seen at a clock edge while the block is idle sets busy and mux_sel at that edge, and the step count becomes 0.
- R3: Each step lasts TICKS_PER_STEP clocks and the cycle has 16 steps (0 to 15). Busy falls at the edge that ends step 15, which is 16*TICKS_PER_STEP clocks after the start edge.
- R4: ras_n is low (row strobe active) during steps 1 to 10 and high at all other times.
- R5: mux_sel is high during steps 0 to 2 and low at all other times.
- R6: cas_n is low (column strobe active) during steps 5 to 11 and high at all other times.
- R7: t6 is high during steps 6 to 9. ack is high during steps 10 and 11.
- R8: wclr is high during step 13 only. At the edge where wclr rises, wr_pend and wr_act clear.
- R9: ostr_n is low only while t6 is high and wr_act is low.
- R10: row_busy is high whenever wr_pend is high or the row strobe is inactive.
- R11: A start while busy has no effect on the strobes or on the write flags. A start held high launches the next cycle at the first edge after busy has fallen.
- R12: At an accepted start, wr_pend takes start_write and wr_act takes start_write AND NOT wr_inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock source |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request to launch a cycle |
| start_write | input | 1 | Cycle carries a write, latched at start |
| wr_inhibit | input | 1 | Blocks the write-active flag, latched at start |
| busy | output | 1 | Cycle in progress |
| mux_sel | output | 1 | Address multiplexer select (row phase) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| t6 | output | 1 | Mid-cycle data window |
| ack | output | 1 | Latch-and-acknowledge pulse |
| wclr | output | 1 | Write-clear pulse |
| ostr_n | output | 1 | Output-store enable, active low |
| row_busy | output | 1 | Row busy flag |
| wr_pend | output | 1 | Write-pending flag |
| wr_act | output | 1 | Write-active flag |

## Verification
The hardest case to reach from the ports is a start that arrives at the boundary of a cycle. Two variants matter: a start that lands in mid-cycle and must not disturb the latched write flags, and a held start that must relaunch exactly one edge after busy falls. The bench reaches the first by pulsing start with start_write high at step 6 of a read cycle and then checking that wr_pend and row_busy still follow the read pattern. It reaches the second by holding start high across the whole cycle, then timing the busy gap cycle by cycle.

// File: rtl/store_cycle_seq.sv
module store_cycle_seq #(
  parameter int TICKS_PER_STEP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  input  logic wr_inhibit,
  output logic busy,
  output logic mux_sel,
  output logic ras_n,
  output logic cas_n,
  output logic t6,
  output logic ack,
  output logic wclr,
  output logic ostr_n,
  output logic row_busy,
  output logic wr_pend,
  output logic wr_act
);
  localparam int TW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_STEP - 1);
  localparam logic [3:0] STEP_LAST = 4'd15;

  logic [TW-1:0] tick;
  logic [3:0]    step;
  logic [3:0]    nxt;
  logic          ras, cas;

  assign nxt = step + 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      step    <= '0;
      busy    <= 1'b0;
      mux_sel <= 1'b0;
      ras     <= 1'b0;
      cas     <= 1'b0;
      t6      <= 1'b0;
      ack     <= 1'b0;
      wclr    <= 1'b0;
      wr_pend <= 1'b0;
      wr_act  <= 1'b0;
    end else if (!busy) begin
      tick <= '0;
      if (start) begin
        busy    <= 1'b1;
        mux_sel <= 1'b1;
        step    <= '0;
        wr_pend <= start_write;
        wr_act  <= start_write & ~wr_inhibit;
      end
    end else if (tick != TICK_LAST) begin
      tick <= tick + TW'(1);
    end else begin
      tick <= '0;
      if (step == STEP_LAST) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= nxt;
        case (nxt)
          4'd1:  ras     <= 1'b1;
          4'd3:  mux_sel <= 1'b0;
          4'd5:  cas     <= 1'b1;
          4'd6:  t6      <= 1'b1;
          4'd10: begin t6 <= 1'b0; ack <= 1'b1; end
          4'd11: ras     <= 1'b0;
          4'd12: begin cas <= 1'b0; ack <= 1'b0; end
          4'd13: begin wclr <= 1'b1; wr_pend <= 1'b0; wr_act <= 1'b0; end
          4'd14: wclr    <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign ras_n    = ~ras;
  assign cas_n    = ~cas;
  assign ostr_n   = ~(t6 & ~wr_act);
  assign row_busy = wr_pend | ~ras;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && !t6 && !ack && !wclr && !mux_sel));
  assert_start_mux_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mux_sel);
  assert_ras_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(busy));
  assert_cas_after_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n);
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t6, ack, wclr}));
  assert_wclr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wclr) |-> (!wr_pend && !wr_act));
  assert_ostr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ostr_n |-> (t6 && !wr_act));
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !wclr) |-> $stable(wr_pend));
endmodule

// File: tb/sim_store_cycle_seq.sv
`timescale 1ns/1ps
module sim_store_cycle_seq;
  localparam int TPS = 5;
  localparam int CYC = 16 * TPS;
  localparam logic [1:0] VEC [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, start_write = 1'b0, wr_inhibit = 1'b0;
  logic busy, mux_sel, ras_n, cas_n, t6, ack, wclr, ostr_n, row_busy, wr_pend, wr_act;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  store_cycle_seq #(.TICKS_PER_STEP(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .wr_inhibit(wr_inhibit), .busy(busy), .mux_sel(mux_sel), .ras_n(ras_n),
    .cas_n(cas_n), .t6(t6), .ack(ack), .wclr(wclr), .ostr_n(ostr_n),
    .row_busy(row_busy), .wr_pend(wr_pend), .wr_act(wr_act));

  task automatic chk(input string tag, input logic act, input logic exp, input int j);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at offset %0d: actual=%b expected=%b", tag, j, act, exp);
    end
  endtask

  task automatic expect_at(input int j, input logic sw, input logic inh);
    int s;
    logic e_busy, e_ras, e_pend, e_act, e_t6;
    s = j / TPS;
    e_busy = (j < CYC);
    if (!e_busy) s = -1;
    e_ras  = (s >= 1 && s <= 10);
    e_t6   = (s >= 6 && s <= 9);
    e_pend = e_busy && sw && s < 13;
    e_act  = e_busy && sw && !inh && s < 13;
    chk("R3 busy", busy, e_busy, j);
    chk("R2 R5 mux_sel", mux_sel, s >= 0 && s <= 2, j);
    chk("R4 ras_n", ras_n, !e_ras, j);
    chk("R6 cas_n", cas_n, !(s >= 5 && s <= 11), j);
    chk("R7 t6", t6, e_t6, j);
    chk("R7 ack", ack, s == 10 || s == 11, j);
    chk("R8 wclr", wclr, s == 13, j);
    chk("R12 R8 wr_pend", wr_pend, e_pend, j);
    chk("R12 R8 wr_act", wr_act, e_act, j);
    chk("R9 ostr_n", ostr_n, !(e_t6 && !e_act), j);
    chk("R10 row_busy", row_busy, e_pend || !e_ras, j);
  endtask

  task automatic launch(input logic sw, input logic inh);
    @(negedge clk);
    start = 1'b1; start_write = sw; wr_inhibit = inh;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; start_write = 1'b0; wr_inhibit = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 1'b0, 0);
    chk("R1 ras_n", ras_n, 1'b1, 0);
    chk("R1 cas_n", cas_n, 1'b1, 0);
    chk("R1 mux_sel", mux_sel, 1'b0, 0);
    chk("R1 ostr_n", ostr_n, 1'b1, 0);
    chk("R1 row_busy", row_busy, 1'b1, 0);
    chk("R1 wr_pend", wr_pend, 1'b0, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      launch(VEC[v][1], VEC[v][0]);
      for (int j = 0; j < CYC + 5; j++) begin
        expect_at(j, VEC[v][1], VEC[v][0]);
        @(negedge clk);
      end
    end

    // R11: mid-cycle start with write must be ignored
    launch(1'b0, 1'b0);
    for (int j = 0; j < CYC + 5; j++) begin
      if (j == 30) begin start = 1'b1; start_write = 1'b1; end
      if (j == 31) begin start = 1'b0; start_write = 1'b0; end
      expect_at(j, 1'b0, 1'b0);
      @(negedge clk);
    end

    // R11: held start relaunches one edge after busy falls
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < CYC; j++) @(negedge clk);
    chk("R11 busy gap", busy, 1'b0, CYC);
    @(negedge clk);
    chk("R11 relaunch busy", busy, 1'b1, CYC + 1);
    chk("R11 relaunch mux_sel", mux_sel, 1'b1, CYC + 1);
    start = 1'b0;

    // R1: reset in mid-cycle returns to idle
    repeat (35) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", busy, 1'b0, 0);
    chk("R1 reset ras_n", ras_n, 1'b1, 0);
    chk("R1 reset cas_n", cas_n, 1'b1, 0);
    chk("R1 reset t6", t6, 1'b0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule